// File: doc/BRIEF.md
# Open-Page-First Request Arbiter with Bounded Bypass

This block keeps an eight-slot, age-ordered queue of pending memory requests. Reads and writes share the queue, and each request records a read/write flag, a bank number and a row number. On every grant it offers one entry to the downstream side. An entry is preferred when it targets the row that is currently open in its bank, even if older requests are still waiting. This raises the proportion of open-row hits, but the oldest request can starve.

A skip counter bounds that starvation. It counts how many grants have gone past the oldest entry. When the count reaches a selectable limit (2, 4, 8 or 16), the arbiter enters a forced state and the oldest entry goes next, whatever the row hits are. Granting the oldest entry clears the counter, and the next-oldest entry becomes the one being tracked. Open rows are modelled as one register per bank. Each grant writes the granted entry's row into that register.

The control is a three-state machine. ST_IDLE means the queue is empty. ST_REORDER allows open-row reordering. ST_FORCE means age order is forced.

The transitions are:
- IDLE→REORDER on an enqueue into an empty queue.
- REORDER→FORCE on a bypass grant that brings the skip count up to the limit.
- REORDER→IDLE when the last entry is granted.
- FORCE→REORDER when the oldest entry is granted and entries remain.
- FORCE→IDLE when the oldest entry is granted and it was the last one.

Top module: `rowhit_arb`

## Requirements
- R1: After reset the queue is empty, `req_ready` is 1, `gnt_valid` is 0, the skip count is 0 and no bank has an open row.
- R2: `req_ready` is 0 exactly when 8 entries are held. A request offered while `req_ready` is 0 is dropped. An accepted request (`req_valid` and `req_ready` both 1 at a rising edge) becomes the youngest entry.
- R3: `gnt_valid` is 1 whenever the queue holds at least one entry. An entry leaves the queue only at a rising edge where `gnt_valid` and `gnt_ready` are both 1.
- R4: Each grant makes the granted row the open row of the granted bank. An entry is a row hit when its bank has an open row equal to the entry's row.
- R5: When age order is not forced and at least one entry is a row hit, the oldest row-hit entry is granted, ahead of any older entries that miss.
- R6: When age order is not forced and no entry is a row hit, the oldest entry is granted.
- R7: A grant to any entry other than the oldest adds one to the skip count. A grant to the oldest entry clears the skip count to 0.
- R8: Once the skip count equals the limit, the next grant goes to the oldest entry, regardless of row hits.
- R9: `lim_sel` picks the limit: 2'b01 gives 2, 2'b10 gives 4, 2'b11 gives 8, and 2'b00 (automatic) gives 16. No code disables reordering. `lim_sel` may change only while the queue is empty.
- R10: `gnt_wr`, `gnt_bank` and `gnt_row` carry the stored fields of the chosen entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Queue has room for a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Bank of the offered request |
| req_row | input | 14 | Row of the offered request |
| lim_sel | input | 2 | Skip-limit select (see R9) |
| gnt_ready | input | 1 | Downstream accepts the offered grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_wr | output | 1 | Read/write flag of the granted entry |
| gnt_bank | output | 3 | Bank of the granted entry |
| gnt_row | output | 14 | Row of the granted entry |

## Verification
`req_ready` and every grant output are driven combinationally from registered state. They therefore reflect, within the same cycle, the enqueues and grants that happened up to the last rising edge. An enqueue or grant handshake updates the queue, the open-row table and the skip counter at that rising edge, so its effect first appears at the outputs in the following cycle. The bench samples all outputs at the falling edge and compares them with a model that has been advanced by exactly the handshakes of the previous edge. Only after that comparison does it drive the next inputs and step the model by the handshakes those inputs will complete.

// File: rtl/rowhit_pkg.sv
package rowhit_pkg;
    parameter int unsigned BANK_W    = 3;
    parameter int unsigned ROW_W     = 14;
    parameter int unsigned Q_DEPTH   = 8;
    parameter int unsigned MAX_LIMIT = 16;

    localparam int unsigned N_BANKS = 1 << BANK_W;
    localparam int unsigned LIM_W   = $clog2(MAX_LIMIT + 1);

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } req_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REORDER = 2'd1,
        ST_FORCE   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/rowhit_queue.sv
module rowhit_queue
    import rowhit_pkg::*;
#(
    parameter int unsigned DEPTH = Q_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  req_ent_t               push_ent,
    input  logic                   pop,
    input  logic [IDX_W-1:0]       pop_idx,
    output req_ent_t [DEPTH-1:0]   slots,
    output logic [CNT_W-1:0]       fill
);
    // slot 0 is always the oldest entry; removal closes the gap by shifting
    req_ent_t [DEPTH-1:0] slot_nxt;
    logic [CNT_W-1:0]     wr_pos;

    assign wr_pos = pop ? fill - 1'b1 : fill;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        req_ent_t above;
        if (i < DEPTH - 1) begin : g_mid
            assign above = slots[i+1];
        end else begin : g_top
            assign above = '0;
        end
        assign slot_nxt[i] = (push && wr_pos == CNT_W'(i)) ? push_ent :
                             (pop && i >= int'(pop_idx))   ? above    :
                                                             slots[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots <= '0;
            fill  <= '0;
        end else begin
            slots <= slot_nxt;
            fill  <= fill + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R2: occupancy never exceeds the depth, and a push always finds room
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    a_r2_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill < CNT_W'(DEPTH) || pop));
    // R3: nothing is removed from an empty queue
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> fill != '0);
endmodule

// File: rtl/rowhit_rows.sv
module rowhit_rows
    import rowhit_pkg::*;
#(
    parameter int unsigned DEPTH = Q_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_upd,
    input  req_ent_t             upd_ent,
    input  req_ent_t [DEPTH-1:0] slots,
    input  logic [CNT_W-1:0]     fill,
    output logic [DEPTH-1:0]     hit
);
    logic [N_BANKS-1:0] row_open;
    logic [ROW_W-1:0]   open_row [N_BANKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_open <= '0;
            for (int b = 0; b < N_BANKS; b++) begin
                open_row[b] <= '0;
            end
        end else if (open_upd) begin
            row_open[upd_ent.bank] <= 1'b1;
            open_row[upd_ent.bank] <= upd_ent.row;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign hit[i] = (CNT_W'(i) < fill) && row_open[slots[i].bank]
                        && (open_row[slots[i].bank] == slots[i].row);
    end

    // R4: a grant leaves its row open in its bank
    a_r4_row_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        open_upd |=> row_open[$past(upd_ent.bank)]
                     && open_row[$past(upd_ent.bank)] == $past(upd_ent.row));
endmodule

// File: rtl/rowhit_pick.sv
module rowhit_pick
    import rowhit_pkg::*;
#(
    parameter int unsigned DEPTH = Q_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hit,
    input  logic             force_oldest,
    output logic [IDX_W-1:0] sel_idx
);
    // lowest index is oldest; scanning downward leaves the oldest hit
    always_comb begin
        sel_idx = '0;
        if (!force_oldest) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (hit[i]) begin
                    sel_idx = IDX_W'(i);
                end
            end
        end
    end

    // R5: with reordering allowed and a hit present, the pick is a hit
    always_comb begin
        if (!force_oldest && (|hit)) begin
            a_r5_pick_is_hit: assert (hit[sel_idx]);
        end
    end
endmodule

// File: rtl/rowhit_arb.sv
module rowhit_arb
    import rowhit_pkg::*;
#(
    parameter int unsigned DEPTH = Q_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [1:0]        lim_sel,
    input  logic              gnt_ready,
    output logic              gnt_valid,
    output logic              gnt_wr,
    output logic [BANK_W-1:0] gnt_bank,
    output logic [ROW_W-1:0]  gnt_row
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    arb_state_e           state, state_nxt;
    logic [LIM_W-1:0]     skip_cnt, skip_nxt, limit;
    logic [CNT_W-1:0]     fill, fill_nxt;
    req_ent_t [DEPTH-1:0] slots;
    req_ent_t             push_ent, chosen;
    logic [DEPTH-1:0]     hit;
    logic [IDX_W-1:0]     sel_idx;
    logic                 push, pop, bypass, force_oldest;

    // limit decode; code 00 is the automatic setting
    always_comb begin
        unique case (lim_sel)
            2'b01:   limit = LIM_W'(2);
            2'b10:   limit = LIM_W'(4);
            2'b11:   limit = LIM_W'(8);
            default: limit = LIM_W'(MAX_LIMIT);
        endcase
    end

    assign push_ent  = '{wr: req_wr, bank: req_bank, row: req_row};
    assign req_ready = fill < CNT_W'(DEPTH);
    assign push      = req_valid && req_ready;
    assign pop       = gnt_valid && gnt_ready;
    assign bypass    = pop && (sel_idx != '0);
    assign fill_nxt  = fill + CNT_W'(push) - CNT_W'(pop);
    assign chosen    = slots[sel_idx];
    assign gnt_wr    = chosen.wr;
    assign gnt_bank  = chosen.bank;
    assign gnt_row   = chosen.row;

    rowhit_queue #(.DEPTH(DEPTH)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .pop_idx  (sel_idx),
        .slots    (slots),
        .fill     (fill)
    );

    rowhit_rows #(.DEPTH(DEPTH)) i_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_upd (pop),
        .upd_ent  (chosen),
        .slots    (slots),
        .fill     (fill),
        .hit      (hit)
    );

    rowhit_pick #(.DEPTH(DEPTH)) i_pick (
        .hit          (hit),
        .force_oldest (force_oldest),
        .sel_idx      (sel_idx)
    );

    // skip counter: bypass grants count up, an oldest grant clears
    always_comb begin
        skip_nxt = skip_cnt;
        if (pop) begin
            skip_nxt = bypass ? skip_cnt + 1'b1 : '0;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (push) state_nxt = ST_REORDER;
            end
            ST_REORDER: begin
                if (bypass && skip_nxt >= limit) state_nxt = ST_FORCE;
                else if (fill_nxt == '0)         state_nxt = ST_IDLE;
            end
            ST_FORCE: begin
                if (pop) state_nxt = (fill_nxt == '0) ? ST_IDLE : ST_REORDER;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            skip_cnt <= '0;
        end else begin
            state    <= state_nxt;
            skip_cnt <= skip_nxt;
        end
    end

    // state outputs
    always_comb begin
        gnt_valid    = 1'b0;
        force_oldest = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_REORDER: gnt_valid = 1'b1;
            ST_FORCE: begin
                gnt_valid    = 1'b1;
                force_oldest = 1'b1;
            end
            default:    ;
        endcase
    end

    // R2: a full queue refuses requests
    a_r2_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        fill == CNT_W'(DEPTH) |-> !req_ready);
    // R3: the idle state matches an empty queue
    a_r3_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) == (fill == '0));
    // R8: the forced state always takes the oldest entry
    a_r8_forced_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORCE && pop) |-> sel_idx == '0);
    // R7: the skip count is cleared by an oldest grant and bumped by a bypass
    a_r7_clear_on_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && sel_idx == '0) |=> skip_cnt == '0);
    a_r7_bump_on_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> skip_cnt == $past(skip_cnt) + 1'b1);
    // R8: the skip count never passes the limit while entries wait
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |-> skip_cnt <= limit);
endmodule

// File: tb/test_rowhit_arb.sv
`timescale 1ns/1ps
module test_rowhit_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_wr = 1'b0, gnt_ready = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [13:0] req_row = '0;
    logic [1:0]  lim_sel = 2'b00;
    logic        req_ready, gnt_valid, gnt_wr;
    logic [2:0]  gnt_bank;
    logic [13:0] gnt_row;

    int nvec = 0;
    int nerr = 0;

    // reference model of the queue, open rows and skip counter
    logic        m_wr   [8];
    logic [2:0]  m_bank [8];
    logic [13:0] m_row  [8];
    bit          m_open [8];
    logic [13:0] m_orow [8];
    int          m_n = 0;
    int          m_cnt = 0;
    int          m_lim = 16;

    always #2.5 clk = ~clk;

    rowhit_arb i_rowhit_arb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_bank(req_bank), .req_row(req_row), .lim_sel(lim_sel),
        .gnt_ready(gnt_ready), .gnt_valid(gnt_valid), .gnt_wr(gnt_wr),
        .gnt_bank(gnt_bank), .gnt_row(gnt_row)
    );

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'b01:   return 2;
            2'b10:   return 4;
            2'b11:   return 8;
            default: return 16;
        endcase
    endfunction

    // why: 0 = oldest with no hit, 1 = oldest hit, 2 = forced oldest
    function automatic void mpick(output int idx, output int why);
        if (m_cnt >= m_lim) begin
            idx = 0; why = 2;
        end else begin
            idx = -1;
            for (int i = 0; i < m_n; i++) begin
                if (idx < 0 && m_open[m_bank[i]] && m_orow[m_bank[i]] == m_row[i]) idx = i;
            end
            if (idx < 0) begin idx = 0; why = 0; end
            else why = 1;
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [2:0] b,
                        input logic [13:0] r, input logic gr);
        int idx = 0;
        int why = 0;
        logic [31:0] exp, got;
        bit fire, acc;
        @(negedge clk);
        chk(req_ready === (m_n < 8), "R2 ready low only when full", 32'(req_ready), 32'(m_n < 8));
        chk(gnt_valid === (m_n != 0), "R3 grant valid when non-empty", 32'(gnt_valid), 32'(m_n != 0));
        if (m_n != 0) begin
            mpick(idx, why);
            exp = {14'd0, m_wr[idx], m_bank[idx], m_row[idx]};
            got = {14'd0, gnt_wr, gnt_bank, gnt_row};
            case (why)
                0: chk(got === exp, "R10 R6 oldest granted with no row hit", got, exp);
                1: chk(got === exp, "R10 R4 R5 oldest row hit granted", got, exp);
                default: chk(got === exp, "R10 R7 R8 R9 oldest forced at limit", got, exp);
            endcase
        end
        req_valid = v; req_wr = w; req_bank = b; req_row = r; gnt_ready = gr;
        fire = (m_n != 0) && gr;
        acc  = v && (m_n < 8);
        if (fire) begin
            m_open[m_bank[idx]] = 1'b1;
            m_orow[m_bank[idx]] = m_row[idx];
            m_cnt = (idx == 0) ? 0 : m_cnt + 1;
            for (int k = idx; k < m_n - 1; k++) begin
                m_wr[k] = m_wr[k+1]; m_bank[k] = m_bank[k+1]; m_row[k] = m_row[k+1];
            end
            m_n--;
        end
        if (acc) begin
            m_wr[m_n] = w; m_bank[m_n] = b; m_row[m_n] = r;
            m_n++;
        end
    endtask

    task automatic drain();
        for (int t = 0; t < 40 && m_n != 0; t++) step(1'b0, 1'b0, 3'd0, 14'd0, 1'b1);
        step(1'b0, 1'b0, 3'd0, 14'd0, 1'b0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R3 watchdog expired: got hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < 8; b++) begin m_open[b] = 1'b0; m_orow[b] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(gnt_valid === 1'b0, "R1 no grant after reset", 32'(gnt_valid), 32'd0);

        // R1/R4: row 0 of bank 0 is not open after reset, so age order is kept
        lim_sel = 2'b01; m_lim = lim_of(2'b01);
        step(1'b1, 1'b0, 3'd1, 14'd7, 1'b0);
        step(1'b1, 1'b1, 3'd0, 14'd0, 1'b0);
        drain();

        // R8 with limit 2: one miss then three hits on bank 1 row 5
        step(1'b1, 1'b0, 3'd1, 14'd5, 1'b0);
        step(1'b0, 1'b0, 3'd0, 14'd0, 1'b1);
        step(1'b1, 1'b1, 3'd2, 14'd9, 1'b0);
        step(1'b1, 1'b0, 3'd1, 14'd5, 1'b0);
        step(1'b1, 1'b1, 3'd1, 14'd5, 1'b0);
        step(1'b1, 1'b0, 3'd1, 14'd5, 1'b0);
        drain();

        // R9 automatic code: 16 bypasses before the miss is forced
        lim_sel = 2'b00; m_lim = lim_of(2'b00);
        step(1'b1, 1'b0, 3'd3, 14'd1, 1'b0);
        step(1'b1, 1'b0, 3'd1, 14'd5, 1'b0);
        for (int t = 0; t < 22; t++) step(1'b1, t[0], 3'd1, 14'd5, 1'b1);
        drain();

        // R2: fill past full while the grant side is stalled
        for (int t = 0; t < 11; t++) step(1'b1, 1'b1, 3'(t), 14'(t), 1'b0);
        drain();

        // constrained random traffic under every limit code
        for (int p = 0; p < 4; p++) begin
            logic [1:0] s;
            s = 2'((p + 1) % 4);
            lim_sel = s; m_lim = lim_of(s);
            for (int t = 0; t < 500; t++) begin
                step(($urandom % 4) != 0, 1'($urandom), 3'($urandom % 4),
                     14'($urandom % 3), ($urandom % 3) != 0);
            end
            drain();
        end

        summary();
        $finish;
    end
endmodule